// File: doc/BRIEF.md
# OR-Gated Routing Switch Tile

This tile is one switch point in the routing fabric of a small programmable logic array. Tracks enter from the four sides: north, east, south and west. Each side carries `W` wires. The tile also receives the output of its own logic cell. It drives tracks out of the four sides and supplies `NL` selected signals to the inputs of the local lookup table.

No selection uses a binary-coded multiplexer. Each selection has a one-hot row of configuration bits, with one bit per candidate. The output is the OR of every candidate whose bit is set. A corrupt or careless configuration can therefore never put two drivers in conflict: enabling several candidates simply merges them into a wired-OR. The same property lets a final OR of control terms be absorbed into a lookup-table input.

On each side, one track is broken at this tile and re-driven from the switch. The broken track rotates with the side and with a placement phase, so that neighbouring tiles break different tracks. Every other track passes straight across the tile.

Configuration enters through a serial chain and is controlled by a three-state sequencer:
- BLANK is the state after reset.
- SHIFT is entered whenever the load enable is sampled high, from BLANK or from LIVE.
- LIVE is entered when the load enable is sampled low while in SHIFT.

Routing outputs are active only in LIVE.

Top module: `orsw_tile`

## Requirements
- R1: During and after reset every configuration bit is 0, the sequencer is in BLANK, and every `trk_out` bit, every `lut_in` bit and `cfg_dout` read 0 for any values on `trk_in` and `cell_out`.
- R2: At each rising clock edge with `cfg_en` high, the chain shifts toward its top: `cfg_din` enters bit 0, and `cfg_dout` always shows the top bit (index CFG_LEN-1). Shifting a vector in top bit first therefore leaves that vector in the chain after CFG_LEN edges, and the previous contents leave on `cfg_dout` top bit first.
- R3: While `cfg_en` is low, the configuration and `cfg_dout` hold their values, whatever `cfg_din` does.
- R4: In the cycle after any edge that sampled `cfg_en` high, every `trk_out` and `lut_in` bit is 0.
- R5: The sequencer moves BLANK to SHIFT and LIVE to SHIFT on `cfg_en` high, and SHIFT to LIVE on `cfg_en` low. BLANK stays in BLANK while `cfg_en` is low. Outputs are driven only in LIVE.
- R6: Track bus index `d*W+t` is track t on side d, with sides numbered north 0, east 1, south 2, west 3. In LIVE, every track t of side d except the broken one gives `trk_out[d*W+t] = trk_in[((d+2)%4)*W+t]`.
- R7: The broken track on side d is t = (PHASE+d)%W. It is driven by the OR of (candidate AND bit) using configuration row d, whose bits are at `d*(3W+1)+j`. For j < 3W the candidate is track j%W of the (j/W)-th other side, counted in increasing side number with d skipped. Candidate j = 3W is `cell_out`.
- R8: Setting several bits in one row yields the OR of the enabled candidates. No pattern of configuration bits gives any other result.
- R9: `lut_in[k]` is the OR of (candidate AND bit) using the bits at `4*(3W+1)+k*(4W+1)+j`. For j < 4W the candidate is `trk_in[j]`, and candidate j = 4W is `cell_out`.
- R10: `cell_out` reaches any broken track or any lookup-table input whose last row bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Load enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out, the top chain bit |
| trk_in | input | 4*W | Incoming tracks, side-major |
| cell_out | input | 1 | Output of the local logic cell |
| trk_out | output | 4*W | Outgoing tracks, side-major |
| lut_in | output | NL | Selected inputs of the local lookup table |

## Verification
The bench builds the tile with W = 3, PHASE = 2 and NL = 4, which gives a 92-bit chain. With three wires per side, the broken-track index wraps modulo W, so sides 0 and 3 break track 2, side 1 breaks track 0 and side 2 breaks track 1. This exercises the rotation rule and the skipped-side candidate numbering on every side, not just the trivial case.

A 92-bit chain is short enough to reload several times: a single-source map, an all-ones map, random maps and an all-zero map. Each reload checks the previous map as it leaves the chain.

// File: rtl/orsw_pkg.sv
package orsw_pkg;

    localparam int NDIR = 4;

    typedef enum logic [1:0] {
        ST_BLANK = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LIVE  = 2'd2
    } orsw_state_e;

    // candidates for one broken track: three other sides plus the cell
    function automatic int sw_cands(input int w);
        return 3 * w + 1;
    endfunction

    // candidates for one lookup-table input: all sides plus the cell
    function automatic int lut_cands(input int w);
        return NDIR * w + 1;
    endfunction

    function automatic int cfg_len(input int w, input int nl);
        return NDIR * sw_cands(w) + nl * lut_cands(w);
    endfunction

    function automatic int brk_track(input int d, input int phase, input int w);
        return (phase + d) % w;
    endfunction

    // k-th side other than d, counted upward with d skipped
    function automatic int other_side(input int d, input int k);
        return (k < d) ? k : k + 1;
    endfunction

    function automatic int opp_side(input int d);
        return (d + 2) % NDIR;
    endfunction

endpackage

// File: rtl/orsw_orsel.sv
module orsw_orsel #(
    parameter int N = 4
) (
    input  logic [N-1:0] cand,
    input  logic [N-1:0] en,
    output logic         y
);
    // one-hot gating: any number of enables merge into an OR
    assign y = |(cand & en);
endmodule

// File: rtl/orsw_cfg_chain.sv
module orsw_cfg_chain
    import orsw_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_en,
    input  logic         cfg_din,
    output logic [N-1:0] cfg_q,
    output logic         cfg_dout,
    output logic         live
);
    orsw_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BLANK;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK: if (cfg_en)  state_d = ST_SHIFT;
            ST_SHIFT: if (!cfg_en) state_d = ST_LIVE;
            ST_LIVE:  if (cfg_en)  state_d = ST_SHIFT;
            default:               state_d = ST_BLANK;
        endcase
    end

    // outputs
    always_comb begin
        live = 1'b0;
        unique case (state_q)
            ST_BLANK: live = 1'b0;
            ST_SHIFT: live = 1'b0;
            ST_LIVE:  live = 1'b1;
            default:  live = 1'b0;
        endcase
    end

    // shift chain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_en) cfg_q <= {cfg_q[N-2:0], cfg_din};
    end

    assign cfg_dout = cfg_q[N-1];
endmodule

// File: rtl/orsw_tile.sv
module orsw_tile
    import orsw_pkg::*;
#(
    parameter int W     = 4,
    parameter int PHASE = 0,
    parameter int NL    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_en,
    input  logic            cfg_din,
    output logic            cfg_dout,
    input  logic [4*W-1:0]  trk_in,
    input  logic            cell_out,
    output logic [4*W-1:0]  trk_out,
    output logic [NL-1:0]   lut_in
);
    localparam int SWN      = sw_cands(W);
    localparam int LTN      = lut_cands(W);
    localparam int CFGN     = cfg_len(W, NL);
    localparam int LUT_BASE = NDIR * SWN;

    logic [CFGN-1:0] cfg_q;
    logic            live;

    orsw_cfg_chain #(.N(CFGN)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .cfg_q    (cfg_q),
        .cfg_dout (cfg_dout),
        .live     (live)
    );

    genvar gd, gt, gj, gk;
    generate
        for (gd = 0; gd < NDIR; gd++) begin : g_side
            for (gt = 0; gt < W; gt++) begin : g_trk
                if (gt == brk_track(gd, PHASE, W)) begin : g_sw
                    logic [SWN-1:0] cand;
                    logic           y;
                    for (gj = 0; gj < 3 * W; gj++) begin : g_c
                        assign cand[gj] = trk_in[other_side(gd, gj / W) * W + gj % W];
                    end
                    assign cand[SWN-1] = cell_out;
                    orsw_orsel #(.N(SWN)) u_sel (
                        .cand (cand),
                        .en   (cfg_q[gd*SWN +: SWN]),
                        .y    (y)
                    );
                    assign trk_out[gd*W+gt] = y & live;
                end else begin : g_pass
                    assign trk_out[gd*W+gt] = trk_in[opp_side(gd)*W+gt] & live;
                end
            end
        end

        for (gk = 0; gk < NL; gk++) begin : g_lut
            logic y;
            orsw_orsel #(.N(LTN)) u_sel (
                .cand ({cell_out, trk_in}),
                .en   (cfg_q[LUT_BASE+gk*LTN +: LTN]),
                .y    (y)
            );
            assign lut_in[gk] = y & live;
        end
    endgenerate
endmodule

// File: rtl/orsw_tile_chk.sv
module orsw_tile_chk
    import orsw_pkg::*;
#(
    parameter int W     = 4,
    parameter int PHASE = 0,
    parameter int NL    = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_en,
    input logic           cfg_dout,
    input logic [4*W-1:0] trk_in,
    input logic [4*W-1:0] trk_out,
    input logic [NL-1:0]  lut_in,
    input logic           live
);
    // R4
    quiet_while_loading_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_en) |-> (trk_out == '0 && lut_in == '0));

    // R5
    live_after_low_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> !$past(cfg_en));

    // R1
    dark_unless_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !live |-> (trk_out == '0 && lut_in == '0));

    // R3
    chain_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_dout));

    genvar gd, gt;
    generate
        for (gd = 0; gd < NDIR; gd++) begin : g_s
            for (gt = 0; gt < W; gt++) begin : g_t
                if (gt != brk_track(gd, PHASE, W)) begin : g_p
                    // R6
                    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
                        live |-> trk_out[gd*W+gt] == trk_in[opp_side(gd)*W+gt]);
                end
            end
        end
    endgenerate
endmodule

bind orsw_tile orsw_tile_chk #(.W(W), .PHASE(PHASE), .NL(NL)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .cfg_dout (cfg_dout),
    .trk_in   (trk_in),
    .trk_out  (trk_out),
    .lut_in   (lut_in),
    .live     (live)
);

// File: tb/orsw_tile_bench.sv
`timescale 1ns/1ps
module orsw_tile_bench;
    localparam int W     = 3;
    localparam int PHASE = 2;
    localparam int NL    = 4;
    localparam int SWN   = 3 * W + 1;
    localparam int LTN   = 4 * W + 1;
    localparam int LB    = 4 * SWN;
    localparam int N     = LB + NL * LTN;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0;
    logic cfg_din = 1'b0;
    logic cfg_dout;
    logic [4*W-1:0] trk_in = '0;
    logic cell_out = 1'b0;
    logic [4*W-1:0] trk_out;
    logic [NL-1:0] lut_in;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [N-1:0] cur_cfg = '0;

    always #5 clk = ~clk;

    orsw_tile #(.W(W), .PHASE(PHASE), .NL(NL)) u_orsw_tile (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .cfg_dout(cfg_dout), .trk_in(trk_in), .cell_out(cell_out),
        .trk_out(trk_out), .lut_in(lut_in)
    );

    function automatic logic [4*W-1:0] exp_trk(input logic [N-1:0] c,
                                               input logic [4*W-1:0] ti, input logic co);
        logic [4*W-1:0] r;
        for (int d = 0; d < 4; d++) begin
            for (int t = 0; t < W; t++) begin
                if (t == (PHASE + d) % W) begin
                    logic a;
                    a = c[d*SWN + 3*W] & co;
                    for (int j = 0; j < 3*W; j++) begin
                        int sd;
                        sd = (j / W < d) ? j / W : j / W + 1;
                        a = a | (c[d*SWN + j] & ti[sd*W + j % W]);
                    end
                    r[d*W+t] = a;
                end else begin
                    r[d*W+t] = ti[((d + 2) % 4)*W + t];
                end
            end
        end
        return r;
    endfunction

    function automatic logic [NL-1:0] exp_lut(input logic [N-1:0] c,
                                              input logic [4*W-1:0] ti, input logic co);
        logic [NL-1:0] r;
        for (int k = 0; k < NL; k++) begin
            logic a;
            a = c[LB + k*LTN + 4*W] & co;
            for (int j = 0; j < 4*W; j++) a = a | (c[LB + k*LTN + j] & ti[j]);
            r[k] = a;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [N-1:0] v);
        for (int i = N - 1; i >= 0; i--) begin
            @(negedge clk);
            chk("R2 old bit on cfg_dout", 64'(cfg_dout), 64'(cur_cfg[i]));
            if (i == N - 2) begin
                chk("R4 tracks quiet in load", 64'(trk_out), 64'(0));
                chk("R4 lut quiet in load", 64'(lut_in), 64'(0));
            end
            cfg_en  = 1'b1;
            cfg_din = v[i];
        end
        @(negedge clk);
        cfg_en = 1'b0;
        chk("R2 new top bit", 64'(cfg_dout), 64'(v[N-1]));
        cur_cfg = v;
        @(negedge clk);
    endtask

    task automatic trial(input logic [4*W-1:0] ti, input logic co, input string tag);
        @(negedge clk);
        trk_in   = ti;
        cell_out = co;
        cfg_din  = 1'($urandom);
        #1;
        chk({tag, " R6/R7 trk_out"}, 64'(trk_out), 64'(exp_trk(cur_cfg, ti, co)));
        chk({tag, " R9 lut_in"}, 64'(lut_in), 64'(exp_lut(cur_cfg, ti, co)));
        chk("R3 cfg_dout held", 64'(cfg_dout), 64'(cur_cfg[N-1]));
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        void'($urandom(32'd1234));

        // R1: reset holds everything dark
        trk_in = '1;
        cell_out = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 trk_out in reset", 64'(trk_out), 64'(0));
        chk("R1 lut_in in reset", 64'(lut_in), 64'(0));
        chk("R1 cfg_dout in reset", 64'(cfg_dout), 64'(0));
        rst_n = 1'b1;

        // R5: BLANK stays dark without a load
        repeat (4) begin
            @(negedge clk);
            trk_in = W'($urandom) | (12'($urandom) << 6);
            cell_out = 1'b1;
            #1;
            chk("R5 blank tracks", 64'(trk_out), 64'(0));
            chk("R5 blank lut", 64'(lut_in), 64'(0));
        end

        // single-source map
        v = '0;
        for (int d = 0; d < 4; d++) v[d*SWN + (d * 2) % (3*W)] = 1'b1;
        v[LB + 4*W] = 1'b1;
        for (int k = 1; k < NL; k++) v[LB + k*LTN + k*W + 1] = 1'b1;
        load(v);
        for (int b = 0; b < 4*W; b++) trial((4*W)'(1) << b, 1'b0, "single");
        trial('0, 1'b1, "R10 single local");

        // all-ones map: every selection is a wired-OR of everything
        load('1);
        trial('0, 1'b0, "R8 ones zero-in");
        trial('0, 1'b1, "R10 ones local");
        for (int b = 0; b < 4*W; b++) trial((4*W)'(1) << b, 1'b0, "R8 ones");

        // random maps with random stimulus
        for (int m = 0; m < 3; m++) begin
            for (int i = 0; i < N; i++) v[i] = 1'($urandom);
            load(v);
            for (int i = 0; i < 80; i++) trial((4*W)'($urandom), 1'($urandom), "R8 random");
        end

        // cleared map: only pass tracks carry data
        load('0);
        for (int i = 0; i < 20; i++) trial((4*W)'($urandom), 1'($urandom), "R7 cleared");

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule